// File: doc/BRIEF.md
# String Transfer Address Sequencer

This block drives the memory side of the string copy operations of a processor core. One start pulse runs one of three operations: a load, which reads one element through the source index into the accumulator; a store, which writes the accumulator through the destination index; and a move, which reads one element through the source index and writes it through the destination index. Each element is a byte, a word or a doubleword. After each element, each index that the operation used moves by the element size, up or down as the direction input selects.

Addresses are built as segment times sixteen plus a 16-bit index. Source accesses use the data segment and destination accesses use the extra segment. In repeat mode a count register sets how many elements run. The index registers, the count and the accumulator are kept in the block and shown at its outputs. A configuration write loads them while the block is idle.

Top module: `str_xfer_seq`

## Requirements
- R1: After reset, busy_o and req_o are 0, and si_o, di_o, cnt_o and acc_o are all zero.
- R2: A load (op_i=0) makes one read (we_o=0) at ds_i*16+si_o. When the read is accepted, only the low 1, 2 or 4 bytes of acc_o (size_i 0, 1 or 2) take the matching bytes of rdata_i. The upper bytes of acc_o keep their old value.
- R3: A store (op_i=1) makes one write (we_o=1) at es_i*16+di_o. wdata_o carries the low element bytes of acc_o, and its upper bytes are zero.
- R4: A move (op_i=2) first makes a read at ds_i*16+si_o. Only after that read is accepted does it make a write at es_i*16+di_o, in the very next cycle. The write carries the element that was read, with its upper bytes zero.
- R5: When an element finishes, each index the operation used changes by 1, 2 or 4 for byte, word or doubleword. It increases when dir_i=0 and decreases when dir_i=1, wrapping modulo 2^16. A load moves only the source index and a store moves only the destination index.
- R6: A request is accepted in a cycle with req_o=1 and ready_i=1. Until then, req_o, we_o, addr_o, size_o and wdata_o stay unchanged.
- R7: With rep_i=1 and a count N>0, exactly N elements run. The count drops by one per element and ends at zero, and busy_o then falls.
- R8: With rep_i=1 and a count of zero, a start makes no request and busy_o stays 0.
- R9: With rep_i=0, exactly one element runs and the count is left unchanged.
- R10: While busy_o=1, start_i and cfg_we_i have no effect. A start with op_i=3 or size_i=3 is ignored.
- R11: Addresses wrap modulo 2^20, so ds_i*16+si_o above 0xFFFFF folds to the bottom of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only while idle |
| op_i | input | 2 | 0 load, 1 store, 2 move, 3 reserved |
| size_i | input | 2 | 0 byte, 1 word, 2 doubleword, 3 reserved |
| dir_i | input | 1 | 0 step indices up, 1 step down |
| rep_i | input | 1 | Use the count register for repetition |
| busy_o | output | 1 | Operation in progress |
| cfg_we_i | input | 1 | Load indices, count and accumulator while idle |
| si_wdata_i | input | 16 | Source index load value |
| di_wdata_i | input | 16 | Destination index load value |
| cnt_wdata_i | input | 16 | Count load value |
| acc_wdata_i | input | 32 | Accumulator load value |
| ds_i | input | 16 | Data segment for source accesses |
| es_i | input | 16 | Extra segment for destination accesses |
| si_o | output | 16 | Source index |
| di_o | output | 16 | Destination index |
| cnt_o | output | 16 | Repeat count |
| acc_o | output | 32 | Accumulator |
| req_o | output | 1 | Memory request valid |
| we_o | output | 1 | 1 write, 0 read |
| addr_o | output | 20 | Byte address |
| size_o | output | 2 | Element size of the request |
| wdata_o | output | 32 | Write data, element in the low bytes |
| rdata_i | input | 32 | Read data, valid with ready_i |
| ready_i | input | 1 | Request accepted this cycle |

## Verification
The hardest cases to reach from the ports are index wrap combined with segment overflow past the top of the 20-bit space, together with a start or configuration write that arrives while an element waits on memory. The bench sweeps every operation, size, direction and repeat setting. It places the indices two or three bytes from 0xFFFF or 0x0000 and sets the data segment to 0xFFFF in half the cases. It holds ready_i low for a varying number of cycles, and during the first wait of each run it injects a junk start and a junk configuration write.

// File: rtl/str_xfer_pkg.sv
package str_xfer_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_STORE = 2'd1, OP_MOVE = 2'd2} str_op_e;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_DWORD = 2'd2} str_size_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RD = 2'd1, ST_WR = 2'd2} str_state_e;

  function automatic logic [DATA_W-1:0] elem_mask(logic [1:0] sz);
    case (sz)
      SZ_BYTE: elem_mask = DATA_W'(32'h0000_00ff);
      SZ_WORD: elem_mask = DATA_W'(32'h0000_ffff);
      default: elem_mask = DATA_W'(32'hffff_ffff);
    endcase
  endfunction
endpackage

// File: rtl/str_addr_gen.sv
module str_addr_gen #(
  parameter int SEG_W  = 16,
  parameter int IDX_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] seg_sh, idx_ext;

  always_comb begin
    seg_sh  = ADDR_W'(seg_i) << SHIFT;
    idx_ext = ADDR_W'(idx_i);
    addr_o  = seg_sh + idx_ext; // carry out dropped: wraps at 2^ADDR_W
  end
endmodule

// File: rtl/str_ctrl.sv
module str_ctrl import str_xfer_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] op_i,
  input  logic [1:0] size_i,
  input  logic       dir_i,
  input  logic       rep_i,
  input  logic       cnt_zero_i,
  input  logic       cnt_one_i,
  input  logic       ready_i,
  output logic       req_o,
  output logic       we_o,
  output logic       busy_o,
  output logic [1:0] op_o,
  output logic [1:0] size_o,
  output logic       dir_o,
  output logic       rep_o,
  output logic       rd_done_o,
  output logic       el_done_o
);
  str_state_e state_q;
  logic [1:0] op_q, size_q;
  logic       dir_q, rep_q, go;

  function automatic str_state_e first_st(logic [1:0] op);
    first_st = (op == OP_STORE) ? ST_WR : ST_RD;
  endfunction

  always_comb begin
    go        = start_i && (state_q == ST_IDLE) && (op_i != 2'd3) && (size_i != 2'd3)
                && !(rep_i && cnt_zero_i);
    req_o     = (state_q != ST_IDLE);
    we_o      = (state_q == ST_WR);
    busy_o    = (state_q != ST_IDLE);
    rd_done_o = (state_q == ST_RD) && ready_i;
    el_done_o = ready_i && ((state_q == ST_WR) || (state_q == ST_RD && op_q == OP_LOAD));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_LOAD;
      size_q  <= SZ_BYTE;
      dir_q   <= 1'b0;
      rep_q   <= 1'b0;
    end else if (go) begin
      state_q <= first_st(op_i);
      op_q    <= op_i;
      size_q  <= size_i;
      dir_q   <= dir_i;
      rep_q   <= rep_i;
    end else if (el_done_o) begin
      state_q <= (rep_q && !cnt_one_i) ? first_st(op_q) : ST_IDLE;
    end else if (rd_done_o) begin
      state_q <= ST_WR; // move: write follows the returned read
    end
  end

  assign op_o   = op_q;
  assign size_o = size_q;
  assign dir_o  = dir_q;
  assign rep_o  = rep_q;

  p_move_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !we_o && ready_i && op_q == OP_MOVE) |=> (req_o && we_o));
  p_hold_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ready_i) |=> (req_o && $stable(we_o)));
  p_zero_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && rep_i && cnt_zero_i) |=> !busy_o);
  p_single_elem_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (el_done_o && !rep_q) |=> !busy_o);
endmodule

// File: rtl/str_regs.sv
module str_regs import str_xfer_pkg::*; #(
  parameter int IDX_W = 16,
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  si_wdata_i,
  input  logic [IDX_W-1:0]  di_wdata_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  input  logic [1:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic              dir_i,
  input  logic              rep_i,
  input  logic              ready_i,
  input  logic              rd_done_i,
  input  logic              el_done_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [IDX_W-1:0]  si_o,
  output logic [IDX_W-1:0]  di_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              cnt_zero_o,
  output logic              cnt_one_o
);
  logic [IDX_W-1:0]  si_q, di_q, step, delta;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] acc_q, buf_q, mask;
  logic              cfg_ok;

  always_comb begin
    mask       = elem_mask(size_i);
    step       = IDX_W'(1) << size_i;
    delta      = dir_i ? (~step + IDX_W'(1)) : step;
    cfg_ok     = cfg_we_i && !busy_i;
    wdata_o    = ((op_i == OP_MOVE) ? buf_q : acc_q) & mask;
    cnt_zero_o = (cnt_q == '0);
    cnt_one_o  = (cnt_q == CNT_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      si_q  <= '0;
      di_q  <= '0;
      cnt_q <= '0;
      acc_q <= '0;
      buf_q <= '0;
    end else if (cfg_ok) begin
      si_q  <= si_wdata_i;
      di_q  <= di_wdata_i;
      cnt_q <= cnt_wdata_i;
      acc_q <= acc_wdata_i;
    end else begin
      if (rd_done_i && op_i == OP_LOAD) acc_q <= (acc_q & ~mask) | (rdata_i & mask);
      if (rd_done_i && op_i == OP_MOVE) buf_q <= rdata_i;
      if (el_done_i) begin
        if (op_i != OP_STORE) si_q <= si_q + delta;
        if (op_i != OP_LOAD)  di_q <= di_q + delta;
        if (rep_i)            cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign si_o  = si_q;
  assign di_o  = di_q;
  assign cnt_o = cnt_q;
  assign acc_o = acc_q;

  p_busy_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !ready_i) |=> ($stable(si_q) && $stable(di_q) && $stable(cnt_q) && $stable(acc_q)));
  p_cnt_down_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (el_done_i && rep_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  p_cnt_kept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (el_done_i && !rep_i) |=> $stable(cnt_q));
  p_src_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (el_done_i && op_i != OP_STORE) |=> (IDX_W'(si_q - $past(si_q)) == $past(delta)));
  p_store_si_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (el_done_i && op_i == OP_STORE) |=> $stable(si_q));
endmodule

// File: rtl/str_xfer_seq.sv
module str_xfer_seq import str_xfer_pkg::*; #(
  parameter int IDX_W     = 16,
  parameter int SEG_W     = 16,
  parameter int CNT_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int ADDR_W   = SEG_W + SEG_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic              dir_i,
  input  logic              rep_i,
  output logic              busy_o,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  si_wdata_i,
  input  logic [IDX_W-1:0]  di_wdata_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  input  logic [SEG_W-1:0]  ds_i,
  input  logic [SEG_W-1:0]  es_i,
  output logic [IDX_W-1:0]  si_o,
  output logic [IDX_W-1:0]  di_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        size_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              ready_i
);
  logic [1:0]        op_q, size_q;
  logic              dir_q, rep_q, rd_done, el_done, cnt_zero, cnt_one;
  logic [ADDR_W-1:0] ea [2];
  logic [SEG_W-1:0]  seg_sel [2];
  logic [IDX_W-1:0]  idx_sel [2];

  str_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i, .op_i, .size_i, .dir_i, .rep_i,
    .cnt_zero_i(cnt_zero), .cnt_one_i(cnt_one), .ready_i,
    .req_o, .we_o, .busy_o,
    .op_o(op_q), .size_o(size_q), .dir_o(dir_q), .rep_o(rep_q),
    .rd_done_o(rd_done), .el_done_o(el_done)
  );

  str_regs #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .busy_i(busy_o), .cfg_we_i,
    .si_wdata_i, .di_wdata_i, .cnt_wdata_i, .acc_wdata_i,
    .op_i(op_q), .size_i(size_q), .dir_i(dir_q), .rep_i(rep_q),
    .ready_i, .rd_done_i(rd_done), .el_done_i(el_done), .rdata_i,
    .si_o, .di_o, .cnt_o, .acc_o, .wdata_o,
    .cnt_zero_o(cnt_zero), .cnt_one_o(cnt_one)
  );

  // port 0: source through data segment, port 1: destination through extra segment
  assign seg_sel[0] = ds_i;
  assign seg_sel[1] = es_i;
  assign idx_sel[0] = si_o;
  assign idx_sel[1] = di_o;

  for (genvar g = 0; g < 2; g++) begin : g_ea
    str_addr_gen #(.SEG_W(SEG_W), .IDX_W(IDX_W), .SHIFT(SEG_SHIFT), .ADDR_W(ADDR_W)) u_ea (
      .seg_i(seg_sel[g]), .idx_i(idx_sel[g]), .addr_o(ea[g])
    );
  end

  assign addr_o = we_o ? ea[1] : ea[0];
  assign size_o = size_q;

  p_hold_addr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ready_i) |=> ($stable(addr_o) && $stable(size_o) && $stable(wdata_o)));
  p_store_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && op_q == OP_STORE) |-> we_o);
  p_load_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && op_q == OP_LOAD) |-> !we_o);
endmodule

// File: tb/str_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module str_xfer_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, dir_i = 1'b0, rep_i = 1'b0, cfg_we_i = 1'b0, ready_i = 1'b0;
  logic [1:0]  op_i = 2'd0, size_i = 2'd0;
  logic [15:0] si_wdata_i = '0, di_wdata_i = '0, cnt_wdata_i = '0, ds_i = '0, es_i = '0;
  logic [31:0] acc_wdata_i = '0, rdata_i = '0;
  logic        busy_o, req_o, we_o;
  logic [15:0] si_o, di_o, cnt_o;
  logic [31:0] acc_o, wdata_o;
  logic [19:0] addr_o;
  logic [1:0]  size_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  str_xfer_seq dut_i (
    .clk_i(clk), .rst_ni, .start_i, .op_i, .size_i, .dir_i, .rep_i, .busy_o,
    .cfg_we_i, .si_wdata_i, .di_wdata_i, .cnt_wdata_i, .acc_wdata_i, .ds_i, .es_i,
    .si_o, .di_o, .cnt_o, .acc_o, .req_o, .we_o, .addr_o, .size_o, .wdata_o,
    .rdata_i, .ready_i
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] pat(logic [19:0] a);
    return (32'(a) * 32'h0101_0107) ^ 32'hA5C3_1E69;
  endfunction

  function automatic logic [19:0] ea(logic [15:0] seg, logic [15:0] idx);
    logic [19:0] s = {seg, 4'h0};
    logic [19:0] i = {4'h0, idx};
    return s + i;
  endfunction

  function automatic logic [31:0] msk(logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic run_case(input int k, input logic [1:0] op, input logic [1:0] sz,
                          input logic dr, input logic rp, input logic [15:0] cnt,
                          input logic [15:0] si, input logic [15:0] di,
                          input logic [15:0] ds, input logic [15:0] es, input logic [31:0] acc);
    logic [15:0] m_si = si, m_di = di, m_cnt = cnt, stp;
    logic [31:0] m_acc = acc, m_buf = '0, exp_wd;
    logic [19:0] exp_a;
    int n_el, n_acc;
    bit first = 1'b1;
    cfg_we_i = 1'b1; si_wdata_i = si; di_wdata_i = di; cnt_wdata_i = cnt; acc_wdata_i = acc;
    ds_i = ds; es_i = es;
    cyc();
    cfg_we_i = 1'b0;
    start_i = 1'b1; op_i = op; size_i = sz; dir_i = dr; rep_i = rp;
    cyc();
    start_i = 1'b0;
    stp = 16'd1 << sz;
    if (rp && cnt == 16'd0) begin
      chk(!busy_o && !req_o, "R8", "zero count start", {busy_o, req_o}, 0);
      cyc();
      chk(!busy_o && !req_o && si_o == si && di_o == di, "R8", "zero count no access",
          {busy_o, req_o, si_o}, {2'b0, si});
      return;
    end
    n_el  = rp ? int'(cnt) : 1;
    n_acc = (op == 2'd2) ? 2 : 1;
    for (int e = 0; e < n_el; e++) begin
      for (int a = 0; a < n_acc; a++) begin
        automatic bit wr = (op == 2'd1) || (a == 1);
        automatic int w  = first ? 2 : (e + a + k) % 3;
        exp_a  = wr ? ea(es, m_di) : ea(ds, m_si);
        exp_wd = (op == 2'd2) ? (m_buf & msk(sz)) : (m_acc & msk(sz));
        for (int i = 0; i < w; i++) begin
          chk(req_o && we_o == wr && addr_o == exp_a, "R6", "held while waiting",
              {11'd0, req_o, addr_o}, {12'd1, exp_a});
          if (first && i == 0) begin
            cfg_we_i = 1'b1; si_wdata_i = 16'h1357; di_wdata_i = 16'h2468;
            cnt_wdata_i = 16'h0077; acc_wdata_i = 32'hDEAD_BEEF;
            start_i = 1'b1; op_i = 2'd1;
          end
          cyc();
          cfg_we_i = 1'b0; start_i = 1'b0;
        end
        first = 1'b0;
        ready_i = 1'b1;
        rdata_i = pat(exp_a);
        chk(req_o && we_o == wr && addr_o == exp_a && size_o == sz,
            (op == 2'd0) ? "R2" : (op == 2'd1) ? "R3" : "R4", "request address",
            {9'd0, we_o, size_o, addr_o}, {9'd0, wr, sz, exp_a});
        if (wr)
          chk(wdata_o == exp_wd, (op == 2'd2) ? "R4" : "R3", "write data", wdata_o, exp_wd);
        cyc();
        ready_i = 1'b0;
        if (!wr && op == 2'd0) m_acc = (m_acc & ~msk(sz)) | (pat(exp_a) & msk(sz));
        if (!wr && op == 2'd2) m_buf = pat(exp_a);
      end
      if (op != 2'd1) m_si = dr ? m_si - stp : m_si + stp;
      if (op != 2'd0) m_di = dr ? m_di - stp : m_di + stp;
      if (rp) m_cnt = m_cnt - 16'd1;
    end
    chk(!busy_o && !req_o, rp ? "R7" : "R9", "idle after last element", {busy_o, req_o}, 0);
    chk(si_o == m_si && di_o == m_di, "R5", "index step", {si_o, di_o}, {m_si, m_di});
    chk(cnt_o == m_cnt, rp ? "R7" : "R9", "count", cnt_o, m_cnt);
    chk(acc_o == m_acc, "R10", "accumulator after junk cfg", acc_o, m_acc);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int k = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy_o && !req_o && si_o == 0 && di_o == 0 && cnt_o == 0 && acc_o == 0, "R1",
        "reset state", {busy_o, req_o, si_o, di_o}, 0);
    rst_ni = 1'b1;
    cyc();
    // sweep: indices two to three bytes from the 16-bit edges, ds=FFFF half the time (R11 wrap)
    for (int op = 0; op < 3; op++)
      for (int sz = 0; sz < 3; sz++)
        for (int dr = 0; dr < 2; dr++)
          for (int rp = 0; rp < 2; rp++) begin
            run_case(k, 2'(op), 2'(sz), dr[0], rp[0],
                     rp ? 16'(1 + k % 3) : 16'd5,
                     dr ? 16'h0001 : 16'hFFFD, dr ? 16'h0002 : 16'hFFFE,
                     k[0] ? 16'hFFFF : 16'(16'h1200 + k), 16'(16'hF000 + 3 * k),
                     32'hC3A5_0F96 ^ 32'(k));
            k++;
          end
    // R11 explicit: FFFF0 + FFFD wraps to 0FFED
    run_case(99, 2'd0, 2'd2, 1'b0, 1'b0, 16'd0, 16'hFFFD, 16'h0000, 16'hFFFF, 16'h0000, 32'h0);
    chk(acc_o == pat(20'h0FFED), "R11", "wrapped load data", acc_o, pat(20'h0FFED));
    // R8: repeat with zero count, every operation
    for (int op = 0; op < 3; op++)
      run_case(200 + op, 2'(op), 2'd1, 1'b0, 1'b1, 16'd0, 16'h0100, 16'h0200,
               16'h0010, 16'h0020, 32'h1111_2222);
    // R10: reserved op and reserved size are ignored
    start_i = 1'b1; op_i = 2'd3; size_i = 2'd0; rep_i = 1'b0;
    cyc();
    start_i = 1'b0;
    chk(!busy_o && !req_o, "R10", "reserved op ignored", {busy_o, req_o}, 0);
    start_i = 1'b1; op_i = 2'd0; size_i = 2'd3;
    cyc();
    start_i = 1'b0;
    chk(!busy_o && !req_o, "R10", "reserved size ignored", {busy_o, req_o}, 0);
    cyc();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule